// File: doc/BRIEF.md
# Partial Mode Decision Cost Engine

This block sits behind a motion-estimation datapath. For every search candidate it receives one motion vector and the distortion (sum of absolute differences) of all 41 variable-size sub-blocks of a macroblock, measured against one reference frame. It adds a rate term to each distortion to form a Lagrangian cost. It keeps the lowest cost and the vector that produced it for every sub-block. When the search ends, it streams out the best vector and cost of each sub-block as a partial result. A later stage combines these partial results across reference frames.

The vector predictor is one macroblock-level value, the component-wise median of the neighbouring macroblock vectors, and a neighbour block computes it. Because every sub-block shares that predictor, the rate term is computed once per candidate and all 41 compare-and-keep cells work in parallel on the same cycle. Candidates enter on a valid/ready stream. The candidate flagged as last closes the search.

Results leave on a second valid/ready stream, one sub-block per beat. Back-pressure rules:
- The output holds its data while `res_ready` is low.
- The input deasserts `cand_ready` from the moment the last candidate is accepted until the final result beat is taken.

No candidate is lost or merged across searches.

Top module: `pmd_cost_engine`

## Requirements
- R1: The rate of a candidate is `lambda * (L(dx) + L(dy) + REF_BITS)`, where dx and dy are the candidate vector minus the predictor. L is the signed exp-Golomb length: codeNum is 2d-1 for d>0 and -2d for d<=0, and L = 2*floor(log2(codeNum+1)) + 1 (so L(0)=1, L(±1)=3, L(±32)=13). Lambda and the predictor are sampled with each accepted candidate.
- R2: The cost of lane b is `sad[b] + rate`, with the same rate for all 41 lanes. Lane b occupies bits `[b*SAD_W +: SAD_W]` of `cand_sad`.
- R3: Each lane keeps the minimum cost over the search and the vector that gave it. A later candidate replaces the kept one only if its cost is strictly lower, so on a tie the earlier candidate in scan order is kept.
- R4: After the last candidate is accepted, exactly 41 result beats are emitted with `res_idx` = 0,1,…,40. Lane 0 is 16x16, 1–2 are 16x8, 3–4 are 8x16, 5–8 are 8x8, 9–16 are 8x4, 17–24 are 4x8 and 25–40 are 4x4. `res_last` is high only on lane 40.
- R5: `cand_ready` is high while candidates are being collected. It is low from the cycle after the last candidate is accepted until the final result beat is accepted.
- R6: While `res_valid` is high and `res_ready` is low, the next cycle keeps `res_valid` high and all result fields unchanged.
- R7: The kept minima are all ones after reset and again after the final result beat. A new search is therefore independent of the previous one, even when its costs are higher.
- R8: Candidate vector components lie within ±SRCH (default 16). Vectors at the range edge are handled and reported exactly.
- R9: After reset, `res_valid` is low and `cand_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lambda | input | LAMBDA_W | Rate multiplier, sampled per candidate |
| pred_mvx | input | MV_W | Predictor horizontal component, signed |
| pred_mvy | input | MV_W | Predictor vertical component, signed |
| cand_valid | input | 1 | Candidate stream valid |
| cand_ready | output | 1 | Candidate stream ready |
| cand_mvx | input | MV_W | Candidate horizontal vector, signed |
| cand_mvy | input | MV_W | Candidate vertical vector, signed |
| cand_sad | input | 41*SAD_W | Distortion of all 41 lanes, packed |
| cand_last | input | 1 | Marks the final candidate of a search |
| res_valid | output | 1 | Result stream valid |
| res_ready | input | 1 | Result stream ready |
| res_idx | output | IDX_W | Sub-block lane of this beat |
| res_mvx | output | MV_W | Best horizontal vector of the lane |
| res_mvy | output | MV_W | Best vertical vector of the lane |
| res_cost | output | COST_W | Best cost of the lane |
| res_last | output | 1 | High on the last lane |

## Verification
In one cycle, the compare-and-keep update for the final candidate lands at the same time as the controller arms the result stream. The first beat must already reflect that candidate. The bench provokes this with a final table candidate that is cheap enough to win many lanes, and with searches of a single candidate. It judges the result against its own cost model, beat by beat. A second overlap is the clearing of the minima on the last result beat while collection reopens. A following search with higher costs must still report its own vectors.

// File: rtl/pmd_pkg.sv
package pmd_pkg;

  localparam int NUM_LANES = 41;

  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_DRAIN   = 2'd1,
    ST_EMIT    = 2'd2
  } pmd_state_e;

  // signed exp-Golomb code length of one vector-difference component
  function automatic logic [5:0] se_len(input logic signed [15:0] d);
    logic [16:0] kp1;
    logic [16:0] neg;
    logic [5:0]  msb;
    neg = 17'd0 - {d[15], d};
    if (d > 16'sd0) kp1 = {d, 1'b0};
    else            kp1 = {neg[15:0], 1'b1};
    msb = 6'd0;
    for (int i = 0; i < 17; i++) begin
      if (kp1[i]) msb = 6'(i);
    end
    return 6'((msb << 1) + 6'd1);
  endfunction

endpackage

// File: rtl/pmd_min_cell.sv
module pmd_min_cell #(
  parameter int SAD_W  = 16,
  parameter int RATE_W = 16,
  parameter int COST_W = 17,
  parameter int MV_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic [SAD_W-1:0]  sad,
  input  logic [RATE_W-1:0] rate,
  input  logic [MV_W-1:0]   mvx,
  input  logic [MV_W-1:0]   mvy,
  output logic [COST_W-1:0] best_cost,
  output logic [MV_W-1:0]   best_mvx,
  output logic [MV_W-1:0]   best_mvy
);
  logic [COST_W-1:0] cand_cost;
  logic              wins;

  assign cand_cost = COST_W'(sad) + COST_W'(rate);
  // strict comparison keeps the earlier candidate on equal cost
  assign wins = cand_cost < best_cost;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      best_cost <= '1;
      best_mvx  <= '0;
      best_mvy  <= '0;
    end else if (clr) begin
      best_cost <= '1;
      best_mvx  <= '0;
      best_mvy  <= '0;
    end else if (upd && wins) begin
      best_cost <= cand_cost;
      best_mvx  <= mvx;
      best_mvy  <= mvy;
    end
  end
endmodule

// File: rtl/pmd_rate_stage.sv
module pmd_rate_stage
  import pmd_pkg::*;
#(
  parameter int MV_W     = 6,
  parameter int LAMBDA_W = 8,
  parameter int SAD_W    = 16,
  parameter int REF_BITS = 1,
  parameter int SUM_W    = 8,
  parameter int RATE_W   = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        acc,
  input  logic [LAMBDA_W-1:0]         lambda,
  input  logic [MV_W-1:0]             pred_mvx,
  input  logic [MV_W-1:0]             pred_mvy,
  input  logic [MV_W-1:0]             mvx,
  input  logic [MV_W-1:0]             mvy,
  input  logic [NUM_LANES*SAD_W-1:0]  sad,
  output logic                        s1_valid,
  output logic [MV_W-1:0]             s1_mvx,
  output logic [MV_W-1:0]             s1_mvy,
  output logic [NUM_LANES*SAD_W-1:0]  s1_sad,
  output logic [RATE_W-1:0]           s1_rate
);
  localparam int PAD_W = 16 - MV_W - 1;

  logic signed [MV_W:0] dx, dy;
  logic [5:0]           len_x, len_y;
  logic [SUM_W-1:0]     len_sum;
  logic [RATE_W-1:0]    rate;

  assign dx = $signed({mvx[MV_W-1], mvx}) - $signed({pred_mvx[MV_W-1], pred_mvx});
  assign dy = $signed({mvy[MV_W-1], mvy}) - $signed({pred_mvy[MV_W-1], pred_mvy});

  assign len_x   = se_len({{PAD_W{dx[MV_W]}}, dx});
  assign len_y   = se_len({{PAD_W{dy[MV_W]}}, dy});
  assign len_sum = SUM_W'(len_x) + SUM_W'(len_y) + SUM_W'(REF_BITS);
  assign rate    = RATE_W'(lambda) * RATE_W'(len_sum);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_mvx   <= '0;
      s1_mvy   <= '0;
      s1_sad   <= '0;
      s1_rate  <= '0;
    end else begin
      s1_valid <= acc;
      if (acc) begin
        s1_mvx  <= mvx;
        s1_mvy  <= mvy;
        s1_sad  <= sad;
        s1_rate <= rate;
      end
    end
  end
endmodule

// File: rtl/pmd_emit_seq.sv
module pmd_emit_seq
  import pmd_pkg::*;
#(
  parameter int MV_W   = 6,
  parameter int COST_W = 17,
  parameter int IDX_W  = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cand_valid,
  input  logic                          cand_last,
  output logic                          cand_ready,
  input  logic [NUM_LANES*COST_W-1:0]   cost_flat,
  input  logic [NUM_LANES*MV_W-1:0]     mvx_flat,
  input  logic [NUM_LANES*MV_W-1:0]     mvy_flat,
  input  logic                          res_ready,
  output logic                          res_valid,
  output logic [IDX_W-1:0]              res_idx,
  output logic                          res_last,
  output logic [COST_W-1:0]             res_cost,
  output logic [MV_W-1:0]               res_mvx,
  output logic [MV_W-1:0]               res_mvy,
  output logic                          clr
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LANES - 1);

  pmd_state_e       state, state_nx;
  logic [IDX_W-1:0] idx, idx_nx;
  logic             beat;

  assign cand_ready = (state == ST_COLLECT);
  assign res_valid  = (state == ST_EMIT);
  assign res_idx    = idx;
  assign res_last   = res_valid && (idx == LAST_IDX);
  assign beat       = res_valid && res_ready;
  assign clr        = beat && (idx == LAST_IDX);

  assign res_cost = cost_flat[idx*COST_W +: COST_W];
  assign res_mvx  = mvx_flat[idx*MV_W +: MV_W];
  assign res_mvy  = mvy_flat[idx*MV_W +: MV_W];

  always_comb begin
    state_nx = state;
    idx_nx   = idx;
    case (state)
      ST_COLLECT: if (cand_valid && cand_last) state_nx = ST_DRAIN;
      ST_DRAIN: begin
        state_nx = ST_EMIT;
        idx_nx   = '0;
      end
      ST_EMIT: if (beat) begin
        if (idx == LAST_IDX) state_nx = ST_COLLECT;
        else                 idx_nx   = idx + 1'b1;
      end
      default: state_nx = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_COLLECT;
      idx   <= '0;
    end else begin
      state <= state_nx;
      idx   <= idx_nx;
    end
  end
endmodule

// File: rtl/pmd_cost_engine.sv
module pmd_cost_engine
  import pmd_pkg::*;
#(
  parameter  int SAD_W    = 16,
  parameter  int MV_W     = 6,
  parameter  int LAMBDA_W = 8,
  parameter  int SRCH     = 16,
  parameter  int REF_BITS = 1,
  localparam int IDX_W    = $clog2(NUM_LANES),
  localparam int SUM_W    = 8,
  localparam int RATE_W   = LAMBDA_W + SUM_W,
  localparam int COST_W   = ((SAD_W > RATE_W) ? SAD_W : RATE_W) + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LAMBDA_W-1:0]        lambda,
  input  logic [MV_W-1:0]            pred_mvx,
  input  logic [MV_W-1:0]            pred_mvy,
  input  logic                       cand_valid,
  output logic                       cand_ready,
  input  logic [MV_W-1:0]            cand_mvx,
  input  logic [MV_W-1:0]            cand_mvy,
  input  logic [NUM_LANES*SAD_W-1:0] cand_sad,
  input  logic                       cand_last,
  output logic                       res_valid,
  input  logic                       res_ready,
  output logic [IDX_W-1:0]           res_idx,
  output logic [MV_W-1:0]            res_mvx,
  output logic [MV_W-1:0]            res_mvy,
  output logic [COST_W-1:0]          res_cost,
  output logic                       res_last
);
  logic                        acc;
  logic                        s1_valid;
  logic [MV_W-1:0]             s1_mvx, s1_mvy;
  logic [NUM_LANES*SAD_W-1:0]  s1_sad;
  logic [RATE_W-1:0]           s1_rate;
  logic                        clr;
  logic [NUM_LANES*COST_W-1:0] cost_flat;
  logic [NUM_LANES*MV_W-1:0]   mvx_flat, mvy_flat;

  assign acc = cand_valid && cand_ready;

  pmd_rate_stage #(
    .MV_W(MV_W), .LAMBDA_W(LAMBDA_W), .SAD_W(SAD_W),
    .REF_BITS(REF_BITS), .SUM_W(SUM_W), .RATE_W(RATE_W)
  ) u_rate (
    .clk(clk), .rst_n(rst_n), .acc(acc), .lambda(lambda),
    .pred_mvx(pred_mvx), .pred_mvy(pred_mvy),
    .mvx(cand_mvx), .mvy(cand_mvy), .sad(cand_sad),
    .s1_valid(s1_valid), .s1_mvx(s1_mvx), .s1_mvy(s1_mvy),
    .s1_sad(s1_sad), .s1_rate(s1_rate)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    pmd_min_cell #(
      .SAD_W(SAD_W), .RATE_W(RATE_W), .COST_W(COST_W), .MV_W(MV_W)
    ) u_cell (
      .clk(clk), .rst_n(rst_n), .clr(clr), .upd(s1_valid),
      .sad(s1_sad[g*SAD_W +: SAD_W]), .rate(s1_rate),
      .mvx(s1_mvx), .mvy(s1_mvy),
      .best_cost(cost_flat[g*COST_W +: COST_W]),
      .best_mvx(mvx_flat[g*MV_W +: MV_W]),
      .best_mvy(mvy_flat[g*MV_W +: MV_W])
    );
  end

  pmd_emit_seq #(.MV_W(MV_W), .COST_W(COST_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cand_valid(cand_valid), .cand_last(cand_last), .cand_ready(cand_ready),
    .cost_flat(cost_flat), .mvx_flat(mvx_flat), .mvy_flat(mvy_flat),
    .res_ready(res_ready), .res_valid(res_valid), .res_idx(res_idx),
    .res_last(res_last), .res_cost(res_cost), .res_mvx(res_mvx),
    .res_mvy(res_mvy), .clr(clr)
  );
endmodule

// File: rtl/pmd_cost_engine_chk.sv
module pmd_cost_engine_chk #(
  parameter int MV_W   = 6,
  parameter int SRCH   = 16,
  parameter int IDX_W  = 6,
  parameter int COST_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cand_valid,
  input logic              cand_ready,
  input logic [MV_W-1:0]   cand_mvx,
  input logic [MV_W-1:0]   cand_mvy,
  input logic              res_valid,
  input logic              res_ready,
  input logic [IDX_W-1:0]  res_idx,
  input logic [MV_W-1:0]   res_mvx,
  input logic [MV_W-1:0]   res_mvy,
  input logic [COST_W-1:0] res_cost,
  input logic              res_last
);
  localparam int LANES = 41;

  // R5: no candidate is taken while results stream out
  assert_no_accept_in_emit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !cand_ready);

  // R6: stalled result beat holds
  assert_hold_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_idx) && $stable(res_cost)
                                   && $stable(res_mvx) && $stable(res_mvy)));

  // R4: lanes advance by one per accepted beat
  assert_lane_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && !res_last) |=> (res_valid && res_idx == IDX_W'($past(res_idx) + 1'b1)));

  // R4: stream starts at lane 0
  assert_first_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> (res_idx == '0));

  // R4: last flag only on the final lane
  assert_last_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_last == (res_idx == IDX_W'(LANES - 1))));

  // R7: every reported lane holds a real candidate, never the cleared value
  assert_no_stale_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_cost != '1));

  // R8: accepted vectors stay inside the search range
  assert_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && cand_ready) |->
      ($signed(cand_mvx) <= SRCH && $signed(cand_mvx) >= -SRCH &&
       $signed(cand_mvy) <= SRCH && $signed(cand_mvy) >= -SRCH));
endmodule

bind pmd_cost_engine pmd_cost_engine_chk #(
  .MV_W(MV_W), .SRCH(SRCH), .IDX_W(IDX_W), .COST_W(COST_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_ready(cand_ready),
  .cand_mvx(cand_mvx), .cand_mvy(cand_mvy), .res_valid(res_valid),
  .res_ready(res_ready), .res_idx(res_idx), .res_mvx(res_mvx),
  .res_mvy(res_mvy), .res_cost(res_cost), .res_last(res_last)
);

// File: tb/pmd_cost_engine_test.sv
`timescale 1ns/1ps
module pmd_cost_engine_test;
  localparam int NB = 41;
  localparam int SW = 16;
  localparam int MW = 6;
  localparam int REFB = 1;
  localparam int NT = 8;
  // table: vector, sad base, sad slope; last row closes the search
  localparam int T_MX[NT]   = '{2, 5, -4, 3, 0, -16, 16, 2};
  localparam int T_MY[NT]   = '{-3, -1, 2, -3, 9, -16, 16, 0};
  localparam int T_BASE[NT] = '{300, 280, 250, 290, 200, 260, 240, 150};
  localparam int T_SL[NT]   = '{7, 3, 11, 5, 13, 2, 9, 4};

  logic clk = 0, rst_n = 0;
  logic [7:0] lambda = 0;
  logic [MW-1:0] pred_mvx = 0, pred_mvy = 0;
  logic cand_valid = 0, cand_last = 0, res_ready = 1;
  logic cand_ready;
  logic [MW-1:0] cand_mvx = 0, cand_mvy = 0;
  logic [NB*SW-1:0] cand_sad = '0;
  logic res_valid, res_last;
  logic [5:0] res_idx;
  logic [MW-1:0] res_mvx, res_mvy;
  logic [16:0] res_cost;

  int checks = 0, fails = 0;
  int exp_cost[NB], exp_mx[NB], exp_my[NB];
  int pmx = 0, pmy = 0, lam = 0;

  always #10 clk = ~clk;

  pmd_cost_engine uut (
    .clk(clk), .rst_n(rst_n), .lambda(lambda), .pred_mvx(pred_mvx), .pred_mvy(pred_mvy),
    .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_mvx(cand_mvx),
    .cand_mvy(cand_mvy), .cand_sad(cand_sad), .cand_last(cand_last),
    .res_valid(res_valid), .res_ready(res_ready), .res_idx(res_idx),
    .res_mvx(res_mvx), .res_mvy(res_mvy), .res_cost(res_cost), .res_last(res_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int eg_len(input int d);
    int code = (d > 0) ? 2 * d - 1 : -2 * d;
    int t = code + 1;
    int n = 1;
    while (t > 1) begin
      t = t / 2;
      n += 2;
    end
    return n;
  endfunction

  function automatic int sadf(input int b, input int base, input int sl);
    return base + ((b * sl + b / 3) % 29);
  endfunction

  task automatic model_clear();
    for (int b = 0; b < NB; b++) begin
      exp_cost[b] = 32'h7fffffff;
      exp_mx[b] = 0;
      exp_my[b] = 0;
    end
  endtask

  task automatic setup(input int l, input int px, input int py);
    lam = l; pmx = px; pmy = py;
    lambda = 8'(l); pred_mvx = MW'(px); pred_mvy = MW'(py);
  endtask

  task automatic send(input int mx, input int my, input int base, input int sl, input bit last);
    int rate;
    @(negedge clk);
    cand_mvx = MW'(mx); cand_mvy = MW'(my); cand_last = last; cand_valid = 1;
    rate = lam * (eg_len(mx - pmx) + eg_len(my - pmy) + REFB);
    for (int b = 0; b < NB; b++) begin
      cand_sad[b*SW +: SW] = SW'(sadf(b, base, sl));
      if (sadf(b, base, sl) + rate < exp_cost[b]) begin
        exp_cost[b] = sadf(b, base, sl) + rate;
        exp_mx[b] = mx;
        exp_my[b] = my;
      end
    end
    while (!cand_ready) @(negedge clk);
    @(posedge clk);
    #1;
    cand_valid = 0; cand_last = 0;
  endtask

  task automatic collect(input string ctag, input string mtag, input int stall_at);
    for (int k = 0; k < NB; k++) begin
      int g = 0;
      @(negedge clk);
      while (!res_valid && g < 200) begin
        @(negedge clk);
        g++;
      end
      chk(res_idx == 6'(k) && res_last == (k == NB - 1), "R4 lane", int'(res_idx), k);
      chk(int'(res_cost) == exp_cost[k], ctag, int'(res_cost), exp_cost[k]);
      chk(int'($signed(res_mvx)) == exp_mx[k] && int'($signed(res_mvy)) == exp_my[k],
          mtag, int'($signed(res_mvx)), exp_mx[k]);
      if (k == stall_at) begin
        res_ready = 0;
        cand_valid = 1;
        for (int s = 0; s < 3; s++) begin
          @(negedge clk);
          chk(res_valid && res_idx == 6'(k) && int'(res_cost) == exp_cost[k],
              "R6 hold", int'(res_idx), k);
          chk(!cand_ready, "R5 ready low in emit", int'(cand_ready), 0);
        end
        cand_valid = 0;
        res_ready = 1;
      end
    end
    @(negedge clk);
    chk(!res_valid && cand_ready, "R5 ready after final beat", int'(cand_ready), 1);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!res_valid, "R9 res_valid after reset", int'(res_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(cand_ready, "R9 cand_ready after reset", int'(cand_ready), 1);
    chk(!res_valid, "R9 idle output", int'(res_valid), 0);

    // table walk: main function, R1 rate and R2 cost per lane
    setup(4, 2, -3);
    model_clear();
    for (int i = 0; i < NT; i++) send(T_MX[i], T_MY[i], T_BASE[i], T_SL[i], i == NT - 1);
    collect("R1/R2 cost", "R3 best vector", -1);

    // R3: equal cost, earlier candidate kept (dx=+1 and dx=-1 share length)
    setup(4, 2, -3);
    model_clear();
    send(3, -3, 100, 5, 0);
    send(1, -3, 100, 5, 1);
    collect("R2 tie cost", "R3 tie keeps earlier", -1);

    // R7: higher costs after a cheap search must still be reported; R5/R6 stall
    setup(0, 0, 0);
    model_clear();
    send(-5, 7, 60000, 1, 1);
    collect("R7 cleared minima cost", "R7 cleared minima vector", 5);

    // R8 and R1 at range edge: dx=+32, dy=-32, lambda changes mid-search
    setup(20, -16, 16);
    model_clear();
    send(-16, 16, 900, 3, 0);
    setup(1, -16, 16);
    send(16, -16, 800, 6, 1);
    collect("R1 edge rate", "R8 edge vector", -1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule